// File: doc/BRIEF.md
# Event-Matrix PWM Timer

This block is a free-running up-counter with a bank of match registers and a small set of events built on top of it. Every event watches one chosen match register. It fires on a counter step where the counter equals that register. Any event can drive any output high or low through two masks kept for each output. A 2-bit code for each output settles the case where a rising and a falling request reach that output on the same step. A limit mask chooses which events send the counter back to zero. This gives every output one shared period. Each match register has a shadow copy. The shadow copy is loaded into the match register at the period boundary, so period and duty can change without glitches.

Software sets the block up through a single-cycle write port. The address holds a 4-bit block number in bits 7:4 and an index in bits 3:0:
- Block 0, general: index 0 is configuration, index 1 is control, index 2 is the limit mask, index 3 is the conflict word.
- Block 1 holds the match registers.
- Block 2 holds the shadow registers.
- Block 3 holds the event controls.
- Block 4 holds the per-output rising masks.
- Block 5 holds the per-output falling masks.

A typical PWM setup works like this. Event 0 matches the period value N-1 and is the only bit in the limit mask. Each duty event matches its own value. Each output rises on event 0 and falls on its duty event.

Top module: `evx_pwm_timer`

## Requirements
- R1: After reset all outputs are low, the counter reads 0 and the timer is halted, so the counter holds at 0 until started.
- R2: The counter advances only while the unify bit (bit 0 of general index 0) is 1 and the halt bit (bit 2 of general index 1) is 0. While halted, the counter and every output hold their values.
- R3: The prescale field (bits 12:5 of general index 1) with value P makes the counter step once every P+1 clocks. An event fires once per matching count, not once per clock.
- R4: An event fires on a count step where the counter equals the match register chosen by bits 3:0 of its control word, but only if bits 13:12 of that word hold 1. Any other mode value, including an all-zero word, turns the event off.
- R5: When an event whose bit is set in the limit mask (general index 2, bit e for event e) fires, the counter steps to 0 instead of incrementing. A period match value of N-1 therefore gives a period of N counts.
- R6: For output o, bit e of the rising mask (block 4, index o) makes event e drive the output high. Bit e of the falling mask (block 5, index o) makes it drive the output low. The output register changes on the clock edge of the firing count, and an output with no firing event holds its value.
- R7: An output that rises on the period event and falls on a duty event matching D, with D < N-1, is high for D+1 of every N counts. With the rise and fall events swapped, it is high for N-1-D counts.
- R8: When rising and falling requests reach output o on the same count, bits 2o+1:2o of the conflict word (general index 3) decide the result: 0 holds, 1 drives high, 2 drives low, 3 inverts. With D = N-1 and code 1 the output stays high for the whole period.
- R9: A shadow register write (block 2) is loaded into the match register of the same index when the counter wraps to 0. A direct match write (block 1) takes effect at once.
- R10: While the no-reload bit (bit 7 of general index 0) is 1, the shadow-to-match copy at the wrap does not happen.
- R11: With the bidirectional bit (bit 4 of general index 1) set, a limit event turns the counter downward. The counter then counts down to 0 and turns upward again, so a limit value of N-1 gives a cycle of 2N-2 counts.
- R12: Outputs are independent. An output whose masks name no firing event stays low, and each output follows only its own masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Write address: block in bits 7:4, index in bits 3:0 |
| wr_data | input | 32 | Write data |
| cnt_o | output | 32 | Current counter value |
| pwm_o | output | 16 | Output levels, one bit per output |

## Verification
The hardest state to reach is the one where the rising and falling requests land on the same count. From the ports this needs a duty event that matches exactly the period value. Reaching it also requires changing the period and duty while the counter runs, without sending the counter past a smaller new limit. The stimulus therefore stages every new period and duty in the shadow registers and waits for wraps, so the change lands on a boundary. It then sets the duty to N-1 under each of the four conflict codes and measures whole-period windows that start at the sample where the counter first reads 0. Random periods and duties, produced from a fixed seed, cover the ordinary duty range between these corner cases.

// File: rtl/evx_pwm_pkg.sv
package evx_pwm_pkg;

    // address block numbers, upper nibble of the write address
    localparam logic [3:0] BLK_GEN    = 4'd0;
    localparam logic [3:0] BLK_MATCH  = 4'd1;
    localparam logic [3:0] BLK_SHADOW = 4'd2;
    localparam logic [3:0] BLK_EVCTL  = 4'd3;
    localparam logic [3:0] BLK_RISE   = 4'd4;
    localparam logic [3:0] BLK_FALL   = 4'd5;

    // field positions inside the general registers
    localparam int UNIFY_BIT  = 0;
    localparam int NOREL_BIT  = 7;
    localparam int HALT_BIT   = 2;
    localparam int BIDIR_BIT  = 4;
    localparam int PRE_LSB    = 5;
    localparam int MODE_LSB   = 12;

    // event mode value that enables a match-only event
    localparam logic [1:0] MODE_MATCH = 2'd1;

    typedef enum logic [1:0] {
        RES_HOLD = 2'd0,
        RES_RISE = 2'd1,
        RES_FALL = 2'd2,
        RES_FLIP = 2'd3
    } res_code_e;

endpackage

// File: rtl/evx_prescaler.sv
module evx_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] pre_d, pre_q;

    assign tick_o = run_i && (pre_q >= div_i);

    always_comb begin
        pre_d = pre_q;
        if (run_i) begin
            pre_d = (pre_q >= div_i) ? '0 : pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R2
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !tick_o);

endmodule

// File: rtl/evx_event_unit.sv
module evx_event_unit #(
    parameter int NUM_EV = 16,
    parameter int CNT_W  = 32,
    parameter int IDX_W  = 4
) (
    input  logic                         tick_i,
    input  logic [CNT_W-1:0]             cnt_i,
    input  logic [NUM_EV-1:0][CNT_W-1:0] match_i,
    input  logic [NUM_EV-1:0][IDX_W-1:0] sel_i,
    input  logic [NUM_EV-1:0][1:0]       mode_i,
    output logic [NUM_EV-1:0]            fire_o
);
    import evx_pwm_pkg::*;

    for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
        assign fire_o[e] = tick_i && (mode_i[e] == MODE_MATCH)
                           && (cnt_i == match_i[sel_i[e]]);
    end

endmodule

// File: rtl/evx_out_matrix.sv
module evx_out_matrix #(
    parameter int NUM_EV  = 16,
    parameter int NUM_OUT = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_EV-1:0]             fire_i,
    input  logic [NUM_OUT-1:0][NUM_EV-1:0] rise_i,
    input  logic [NUM_OUT-1:0][NUM_EV-1:0] fall_i,
    input  logic [2*NUM_OUT-1:0]          res_i,
    output logic [NUM_OUT-1:0]            pwm_o
);
    import evx_pwm_pkg::*;

    logic [NUM_OUT-1:0] pwm_d, pwm_q;
    logic [NUM_OUT-1:0] up_hit, dn_hit;

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_hit
        assign up_hit[o] = |(fire_i & rise_i[o]);
        assign dn_hit[o] = |(fire_i & fall_i[o]);

        // R8
        conflict_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (up_hit[o] && dn_hit[o] && res_i[2*o +: 2] == RES_FALL) |=> !pwm_q[o]);

        // R8
        conflict_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (up_hit[o] && dn_hit[o] && res_i[2*o +: 2] == RES_FLIP)
            |=> (pwm_q[o] != $past(pwm_q[o])));
    end

    always_comb begin
        pwm_d = pwm_q;
        for (int o = 0; o < NUM_OUT; o++) begin
            if (up_hit[o] && dn_hit[o]) begin
                case (res_code_e'(res_i[2*o +: 2]))
                    RES_RISE: pwm_d[o] = 1'b1;
                    RES_FALL: pwm_d[o] = 1'b0;
                    RES_FLIP: pwm_d[o] = ~pwm_q[o];
                    default:  pwm_d[o] = pwm_q[o];
                endcase
            end else if (up_hit[o]) begin
                pwm_d[o] = 1'b1;
            end else if (dn_hit[o]) begin
                pwm_d[o] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= '0;
        else        pwm_q <= pwm_d;
    end

    assign pwm_o = pwm_q;

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i == '0) |=> $stable(pwm_q));

endmodule

// File: rtl/evx_pwm_timer.sv
module evx_pwm_timer #(
    parameter int NUM_EV  = 16,
    parameter int NUM_OUT = 16,
    parameter int CNT_W   = 32,
    parameter int PRE_W   = 8,
    parameter int DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [4+$clog2(NUM_EV)-1:0] wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [CNT_W-1:0]    cnt_o,
    output logic [NUM_OUT-1:0]  pwm_o
);
    import evx_pwm_pkg::*;

    localparam int IDX_W  = $clog2(NUM_EV);
    localparam int ADDR_W = 4 + IDX_W;

    typedef struct packed {
        logic                          unify;
        logic                          norel;
        logic                          halt;
        logic                          bidir;
        logic [PRE_W-1:0]              presc;
        logic [NUM_EV-1:0]             limit;
        logic [2*NUM_OUT-1:0]          res;
        logic [CNT_W-1:0]              cnt;
        logic                          down;
        logic [NUM_EV-1:0][CNT_W-1:0]  match;
        logic [NUM_EV-1:0][CNT_W-1:0]  shadow;
        logic [NUM_EV-1:0][IDX_W-1:0]  evsel;
        logic [NUM_EV-1:0][1:0]        evmode;
        logic [NUM_OUT-1:0][NUM_EV-1:0] rise;
        logic [NUM_OUT-1:0][NUM_EV-1:0] fall;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    logic              tick;
    logic [NUM_EV-1:0] fire;
    logic              hit_lim;
    logic              wrap;
    logic [3:0]        blk;
    logic [IDX_W-1:0]  idx;

    assign blk     = wr_addr[ADDR_W-1 -: 4];
    assign idx     = wr_addr[IDX_W-1:0];
    assign hit_lim = |(fire & st_q.limit);

    evx_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.unify && !st_q.halt),
        .div_i  (st_q.presc),
        .tick_o (tick)
    );

    evx_event_unit #(.NUM_EV(NUM_EV), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_ev (
        .tick_i  (tick),
        .cnt_i   (st_q.cnt),
        .match_i (st_q.match),
        .sel_i   (st_q.evsel),
        .mode_i  (st_q.evmode),
        .fire_o  (fire)
    );

    evx_out_matrix #(.NUM_EV(NUM_EV), .NUM_OUT(NUM_OUT)) i_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .rise_i (st_q.rise),
        .fall_i (st_q.fall),
        .res_i  (st_q.res),
        .pwm_o  (pwm_o)
    );

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;

        // counter stepping
        if (tick) begin
            if (st_q.bidir && st_q.down) begin
                if (st_q.cnt == '0) begin
                    st_d.down = 1'b0;
                    st_d.cnt  = CNT_W'(1);
                    wrap      = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end else if (hit_lim) begin
                if (st_q.bidir) begin
                    st_d.down = 1'b1;
                    st_d.cnt  = (st_q.cnt == '0) ? '0 : st_q.cnt - CNT_W'(1);
                end else begin
                    st_d.cnt = '0;
                    wrap     = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (!st_q.bidir) st_d.down = 1'b0;

        // shadow load at the period boundary
        if (wrap && !st_q.norel) st_d.match = st_q.shadow;

        // register writes take priority over the shadow load
        if (wr_en) begin
            case (blk)
                BLK_GEN: begin
                    case (idx)
                        IDX_W'(0): begin
                            st_d.unify = wr_data[UNIFY_BIT];
                            st_d.norel = wr_data[NOREL_BIT];
                        end
                        IDX_W'(1): begin
                            st_d.halt  = wr_data[HALT_BIT];
                            st_d.bidir = wr_data[BIDIR_BIT];
                            st_d.presc = wr_data[PRE_LSB +: PRE_W];
                        end
                        IDX_W'(2): st_d.limit = wr_data[NUM_EV-1:0];
                        IDX_W'(3): st_d.res   = wr_data[2*NUM_OUT-1:0];
                        default: ;
                    endcase
                end
                BLK_MATCH:  st_d.match[idx]  = wr_data[CNT_W-1:0];
                BLK_SHADOW: st_d.shadow[idx] = wr_data[CNT_W-1:0];
                BLK_EVCTL: begin
                    st_d.evsel[idx]  = wr_data[IDX_W-1:0];
                    st_d.evmode[idx] = wr_data[MODE_LSB +: 2];
                end
                BLK_RISE: if (int'(idx) < NUM_OUT) st_d.rise[idx] = wr_data[NUM_EV-1:0];
                BLK_FALL: if (int'(idx) < NUM_OUT) st_d.fall[idx] = wr_data[NUM_EV-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.halt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R3
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.cnt));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hit_lim && !st_q.bidir) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    // R5
    limit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit_lim && !st_q.bidir) |=> (st_q.cnt == '0));

    // R11
    bidir_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit_lim && st_q.bidir && !st_q.down) |=> st_q.down);

endmodule

// File: tb/test_evx_pwm_timer.sv
module test_evx_pwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] cnt_o;
    logic [15:0] pwm_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    evx_pwm_timer i_evx_pwm_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cnt_o   (cnt_o),
        .pwm_o   (pwm_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog (R1..) actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] blk, input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = {blk, idx};
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // returns at the first negedge sample where the counter has just become 0
    task automatic wait_wrap();
        logic [31:0] prev;
        prev = cnt_o;
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (prev != 0 && cnt_o == 0) break;
            prev = cnt_o;
        end
    endtask

    task automatic period_cycles(output int p);
        logic [31:0] prev;
        wait_wrap();
        p = 0;
        for (int g = 0; g < 5000; g++) begin
            prev = cnt_o;
            @(negedge clk);
            p++;
            if (prev != 0 && cnt_o == 0) break;
        end
    endtask

    task automatic high_over(input int o, input int n, output int h);
        h = 0;
        for (int k = 0; k < n; k++) begin
            if (pwm_o[o]) h++;
            @(negedge clk);
        end
    endtask

    // expected high counts per period for an output rising on the period
    // event and falling on a duty event at D, conflict code c
    function automatic int exp_high(input int d, input int n, input int c);
        if (d < n - 1) return d + 1;
        if (c == 1) return n;
        return 0;
    endfunction

    int h, h2, p, n, d, seed;
    logic [31:0] c0;
    logic [15:0] po;

    initial begin
        seed = $urandom(32'd7351);
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(cnt_o == 0, "R1 cnt after reset", cnt_o, 0);
        chk(pwm_o == 0, "R1 pwm after reset", pwm_o, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(cnt_o == 0, "R1 halted after reset", cnt_o, 0);

        // R2 running but unify clear: no counting
        wr(4'd0, 4'd1, 32'h0);
        repeat (10) @(negedge clk);
        chk(cnt_o == 0, "R2 no count without unify", cnt_o, 0);

        // basic setup: halt, N=10, D=4
        wr(4'd0, 4'd1, 32'h4);
        wr(4'd1, 4'd0, 32'd9);  wr(4'd2, 4'd0, 32'd9);
        wr(4'd1, 4'd1, 32'd4);  wr(4'd2, 4'd1, 32'd4);
        wr(4'd3, 4'd0, 32'h1000);
        wr(4'd3, 4'd1, 32'h1001);
        wr(4'd0, 4'd2, 32'h1);
        wr(4'd4, 4'd0, 32'h1);
        wr(4'd5, 4'd0, 32'h2);
        wr(4'd0, 4'd3, 32'h1);
        wr(4'd0, 4'd0, 32'h1);
        wr(4'd0, 4'd1, 32'h0);

        period_cycles(p);
        chk(p == 10, "R5 period of N counts", p, 10);
        wait_wrap();
        high_over(0, 10, h);
        chk(h == 5, "R7 duty D+1 high", h, 5);
        chk(pwm_o[15:1] == 0, "R12 unused outputs low", pwm_o[15:1], 0);

        // random periods and duties staged through the shadow registers
        for (int it = 0; it < 10; it++) begin
            n = 4 + int'($urandom_range(36));
            d = int'($urandom_range(n - 1));
            wr(4'd2, 4'd0, 32'(n - 1));
            wr(4'd2, 4'd1, 32'(d));
            wait_wrap();
            wait_wrap();
            high_over(0, n, h);
            chk(h == exp_high(d, n, 1), "R9 R7 random duty", h, exp_high(d, n, 1));
            period_cycles(p);
            chk(p == n, "R5 R9 random period", p, n);
        end

        // back to N=10, D=4
        wr(4'd2, 4'd0, 32'd9);
        wr(4'd2, 4'd1, 32'd4);
        wait_wrap(); wait_wrap();

        // R10 no-reload: direct match write sticks, shadow ignored
        wr(4'd0, 4'd0, 32'h81);
        wr(4'd2, 4'd1, 32'd7);
        wr(4'd1, 4'd1, 32'd2);
        wait_wrap(); wait_wrap();
        high_over(0, 10, h);
        chk(h == 3, "R10 shadow ignored, R9 direct match", h, 3);
        wr(4'd0, 4'd0, 32'h1);
        wait_wrap(); wait_wrap();
        high_over(0, 10, h);
        chk(h == 8, "R9 shadow loaded after no-reload cleared", h, 8);

        // R8 conflict codes with D = N-1
        wr(4'd2, 4'd1, 32'd9);
        wr(4'd0, 4'd3, 32'h1);
        wait_wrap(); wait_wrap();
        high_over(0, 10, h);
        chk(h == exp_high(9, 10, 1), "R8 code set full duty", h, 10);
        wr(4'd0, 4'd3, 32'h0);
        wait_wrap(); wait_wrap();
        high_over(0, 10, h);
        chk(h == 10, "R8 code hold keeps high", h, 10);
        wr(4'd0, 4'd3, 32'h2);
        wait_wrap(); wait_wrap();
        high_over(0, 10, h);
        chk(h == exp_high(9, 10, 2), "R8 code clear zero duty", h, 0);
        wr(4'd0, 4'd3, 32'h0);
        wait_wrap(); wait_wrap();
        high_over(0, 10, h);
        chk(h == 0, "R8 code hold keeps low", h, 0);
        wr(4'd0, 4'd3, 32'h3);
        wait_wrap(); wait_wrap();
        high_over(0, 10, h);
        high_over(0, 10, h2);
        chk(h + h2 == 10 && (h == 0 || h == 10), "R8 code toggle alternates", h + h2, 10);

        // R4 event enable and selection, D=4, code set
        wr(4'd0, 4'd3, 32'h1);
        wr(4'd2, 4'd1, 32'd4);
        wait_wrap(); wait_wrap();
        high_over(0, 10, h);
        chk(h == 5, "R4 enabled event", h, 5);
        wr(4'd3, 4'd1, 32'h0001);
        wait_wrap(); wait_wrap();
        high_over(0, 10, h);
        chk(h == 10, "R4 mode 0 disables event", h, 10);
        wr(4'd3, 4'd1, 32'h2001);
        wait_wrap(); wait_wrap();
        high_over(0, 10, h);
        chk(h == 10, "R4 mode 2 disables event", h, 10);
        wr(4'd2, 4'd3, 32'd6);
        wr(4'd1, 4'd3, 32'd6);
        wr(4'd3, 4'd1, 32'h1003);
        wait_wrap(); wait_wrap();
        high_over(0, 10, h);
        chk(h == 7, "R4 event selects match 3", h, 7);
        wr(4'd3, 4'd1, 32'h1001);

        // R12 independent outputs, R7 swapped polarity, R6 masks
        wr(4'd2, 4'd1, 32'd3);
        wr(4'd2, 4'd2, 32'd1);
        wr(4'd3, 4'd2, 32'h1002);
        wr(4'd4, 4'd5, 32'h1);
        wr(4'd5, 4'd5, 32'h4);
        wr(4'd4, 4'd7, 32'h2);
        wr(4'd5, 4'd7, 32'h1);
        wait_wrap(); wait_wrap();
        high_over(0, 10, h);
        chk(h == 4, "R12 out0 own duty", h, 4);
        wait_wrap();
        high_over(5, 10, h);
        chk(h == 2, "R6 R12 out5 own masks", h, 2);
        wait_wrap();
        high_over(7, 10, h);
        chk(h == 6, "R7 swapped rise/fall N-1-D", h, 6);
        chk(pwm_o[4] == 0 && pwm_o[15:8] == 0, "R12 unmapped outputs low",
            {pwm_o[15:8], pwm_o[4]}, 0);

        // R3 prescaler: 4 clocks per count, events once per count
        wr(4'd0, 4'd1, 32'(3 << 5));
        period_cycles(p);
        chk(p == 40, "R3 prescaled period", p, 40);
        wait_wrap();
        high_over(0, 40, h);
        chk(h == 16, "R3 duty scales with prescale", h, 16);

        // R2 halt freezes counter and outputs
        wr(4'd0, 4'd1, 32'h4);
        c0 = cnt_o;
        po = pwm_o;
        repeat (25) @(negedge clk);
        chk(cnt_o == c0, "R2 counter frozen when halted", cnt_o, c0);
        chk(pwm_o == po, "R2 outputs frozen when halted", pwm_o, po);

        // R11 bidirectional counting
        wr(4'd0, 4'd1, 32'h10);
        period_cycles(p);
        chk(p == 18, "R11 up-down cycle 2N-2", p, 18);
        period_cycles(p);
        chk(p == 18, "R11 second up-down cycle", p, 18);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule